// File: doc/BRIEF.md
# Flash Bank Writer

This block is a hardware sequencer that rewrites one bank of a byte-wide flash device that takes commands through a command register and reports progress through a status byte. A start pulse picks either a bank erase or a bank program, and a bank index. The block then issues the device command bytes on a simple flash bus and polls the device until its ready bit is set. Each poll loop is bounded by a try limit. The block puts the device back into array-read mode and reads every byte of the bank back to confirm the result. In program mode, source bytes come from a local buffer through an address/data port with one cycle of read latency.

The controller is one state machine with twelve states. S_IDLE goes to S_CMD_A on an accepted start. S_CMD_A writes the first command byte. In program mode it moves to S_SETUP_WAIT, which holds for the setup gap; in erase mode it goes straight to S_CMD_B. S_CMD_B writes the erase confirm or the data byte and enters the poll loop. The poll loop runs S_POLL_CMD, which writes the status-read command, then S_POLL_RD, which reads, then S_POLL_CHK. S_POLL_CHK returns to S_POLL_CMD while the device is busy and tries remain. When the device is ready, it goes to S_CMD_A for the next byte, or to S_CLR_ST after the last byte or after an erase. When the tries are used up, it goes to S_CLR_ST. S_CLR_ST writes the status-clear command. S_RST_RD writes the array-read command. The verify walk then alternates S_VFY_RD and S_VFY_CHK over the whole bank and ends in S_FINISH, which pulses done and returns to S_IDLE.

The bank size and the bank count must be powers of two, with at least two banks. A bank base address is the bank index times the bank size, so the flash address is the bank index concatenated above the byte offset. With a 250 MHz clock, the default setup gap of 250 cycles gives about 1 µs.

Top module: `flash_bank_writer`

## Requirements
- R1: A start while idle sets busy from the next cycle. Busy stays high until done, which is high for exactly one cycle. In the cycle after done, busy is low.
- R2: In erase mode (op_prog=0), the first two bus writes are 0x20 and then 0xD0. Every write of an erase operation goes to the bank base (bank_sel × BANK_BYTES).
- R3: In program mode (op_prog=1), each byte i begins with a write of 0x40 to base+i. Exactly SETUP_CYC cycles with no bus strobe follow. The next write puts src byte i at base+i, so it comes SETUP_CYC+1 cycles after the 0x40 write.
- R4: A poll is a write of 0x70 to the base followed by a read. Status bit 7 set ends the poll loop. The write and read strobes are never high together.
- R5: A poll loop that reaches POLL_LIMIT polls without bit 7 sets timeout_flag. After a timeout in program mode, no further byte is programmed.
- R6: Every operation, including one that timed out, ends its command phase with a write of 0x50 and then a write of 0xFF, both at the base.
- R7: After an erase, every byte of the bank is read back. A byte that is not 0xFF sets vfy_fail.
- R8: After a program, every byte of the bank is read back. A byte that differs from its source byte sets vfy_fail.
- R9: If the status byte that ends a poll loop has any of bits 5..3 (mask 0x38) set, dev_err is set.
- R10: A start while busy is ignored. The operation in progress keeps its mode and bank.
- R11: After reset the block is idle, with busy, done, every flag and both bus strobes low.
- R12: An accepted start clears timeout_flag, vfy_fail and dev_err from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| op_prog | input | 1 | 1 selects program, 0 selects erase |
| bank_sel | input | log2(NUM_BANKS) | Bank to work on |
| busy | output | 1 | High from the cycle after start until done |
| done | output | 1 | One-cycle pulse at the end of an operation |
| timeout_flag | output | 1 | A poll loop ran out of tries |
| vfy_fail | output | 1 | Read-back found a wrong byte |
| dev_err | output | 1 | Device status reported an error bit |
| fl_addr | output | log2(NUM_BANKS)+log2(BANK_BYTES) | Flash byte address |
| fl_wdata | output | 8 | Flash write data or command byte |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe; data is expected one cycle later |
| fl_rdata | input | 8 | Flash read data |
| src_addr | output | log2(BANK_BYTES) | Source buffer byte address |
| src_data | input | 8 | Source byte for the address of the previous cycle |

## Verification
On every cycle, the assertions check the busy and done handshake, that the two strobes never overlap, and that erase writes stay on the bank base. They also check that a start during an operation changes neither the mode nor the bank, that the flags clear on acceptance, that a timeout is always followed by the wrap-up commands, and that both try counters stay in range. Only the bench's scenarios, run against a behavioural flash model, can show the actual command order, the exact setup gap, the number of polls before a timeout, that programming stops after a timeout, and that the read-back really flags a stuck cell, an unerased byte or a status error.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD_A,
        S_SETUP_WAIT,
        S_CMD_B,
        S_POLL_CMD,
        S_POLL_RD,
        S_POLL_CHK,
        S_CLR_ST,
        S_RST_RD,
        S_VFY_RD,
        S_VFY_CHK,
        S_FINISH
    } fbw_state_e;

    typedef enum logic {
        OP_ERASE = 1'b0,
        OP_PROG  = 1'b1
    } fbw_op_e;

    // Device command bytes
    localparam logic [7:0] FC_ERASE_ARM  = 8'h20;
    localparam logic [7:0] FC_ERASE_GO   = 8'hD0;
    localparam logic [7:0] FC_PROG_ARM   = 8'h40;
    localparam logic [7:0] FC_STAT_READ  = 8'h70;
    localparam logic [7:0] FC_STAT_CLEAR = 8'h50;
    localparam logic [7:0] FC_ARRAY_MODE = 8'hFF;

    // Status byte decoding
    localparam int         STAT_READY_BIT = 7;
    localparam logic [7:0] STAT_ERR_MASK  = 8'h38;
    localparam logic [7:0] ERASED_BYTE    = 8'hFF;

endpackage

// File: rtl/fbw_counter.sv
// Up counter with synchronous clear; wraps to zero after LIMIT-1.
module fbw_counter #(
    parameter int LIMIT = 2,
    parameter int W     = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_last
);

    assign at_last = (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= at_last ? '0 : cnt + W'(1);
        end
    end

endmodule

// File: rtl/fbw_status_eval.sv
// Splits a device status byte into ready and fault indications.
module fbw_status_eval
    import fbw_pkg::*;
(
    input  logic [7:0] stat,
    output logic       ready,
    output logic       fault
);

    always_comb begin
        ready = stat[STAT_READY_BIT];
        fault = |(stat & STAT_ERR_MASK);
    end

endmodule

// File: rtl/flash_bank_writer.sv
module flash_bank_writer
    import fbw_pkg::*;
#(
    parameter int BANK_BYTES = 8192,
    parameter int NUM_BANKS  = 2,
    parameter int SETUP_CYC  = 250,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              start,
    input  logic                                              op_prog,
    input  logic [$clog2(NUM_BANKS)-1:0]                      bank_sel,
    output logic                                              busy,
    output logic                                              done,
    output logic                                              timeout_flag,
    output logic                                              vfy_fail,
    output logic                                              dev_err,
    output logic [$clog2(NUM_BANKS)+$clog2(BANK_BYTES)-1:0]   fl_addr,
    output logic [7:0]                                        fl_wdata,
    output logic                                              fl_we,
    output logic                                              fl_re,
    input  logic [7:0]                                        fl_rdata,
    output logic [$clog2(BANK_BYTES)-1:0]                     src_addr,
    input  logic [7:0]                                        src_data
);

    localparam int AW = $clog2(BANK_BYTES);
    localparam int BW = $clog2(NUM_BANKS);
    localparam int GW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
    localparam int PW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

    fbw_state_e     state, state_nx;
    fbw_op_e        op_q;
    logic [BW-1:0]  bank_q;

    logic [AW-1:0]  idx;
    logic           idx_last;
    logic [GW-1:0]  gap_cnt;
    logic           gap_last;
    logic [PW-1:0]  poll_cnt;
    logic           poll_last;

    logic           st_ready, st_fault;
    logic           accept;
    logic [7:0]     expect_byte;
    logic           mismatch;

    assign accept      = (state == S_IDLE) && start;
    assign expect_byte = (op_q == OP_PROG) ? src_data : ERASED_BYTE;
    assign mismatch    = (fl_rdata != expect_byte);

    // Byte index: shared by the program loop and the read-back walk
    fbw_counter #(.LIMIT(BANK_BYTES), .W(AW)) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept || (state == S_RST_RD)),
        .inc     (((state == S_POLL_CHK) && st_ready && (op_q == OP_PROG) && !idx_last) ||
                  ((state == S_VFY_CHK) && !idx_last)),
        .cnt     (idx),
        .at_last (idx_last)
    );

    // Setup gap between program arm and data write
    fbw_counter #(.LIMIT(SETUP_CYC), .W(GW)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state != S_SETUP_WAIT),
        .inc     (state == S_SETUP_WAIT),
        .cnt     (gap_cnt),
        .at_last (gap_last)
    );

    // Poll tries, restarted for each poll loop
    fbw_counter #(.LIMIT(POLL_LIMIT), .W(PW)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == S_CMD_B),
        .inc     ((state == S_POLL_CHK) && !st_ready),
        .cnt     (poll_cnt),
        .at_last (poll_last)
    );

    fbw_status_eval u_stat (
        .stat  (fl_rdata),
        .ready (st_ready),
        .fault (st_fault)
    );

    // State register, latched command and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            op_q         <= OP_ERASE;
            bank_q       <= '0;
            timeout_flag <= 1'b0;
            vfy_fail     <= 1'b0;
            dev_err      <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                op_q         <= fbw_op_e'(op_prog);
                bank_q       <= bank_sel;
                timeout_flag <= 1'b0;
                vfy_fail     <= 1'b0;
                dev_err      <= 1'b0;
            end
            if (state == S_POLL_CHK) begin
                if (st_ready && st_fault) begin
                    dev_err <= 1'b1;
                end
                if (!st_ready && poll_last) begin
                    timeout_flag <= 1'b1;
                end
            end
            if ((state == S_VFY_CHK) && mismatch) begin
                vfy_fail <= 1'b1;
            end
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (start) state_nx = S_CMD_A;
            S_CMD_A:      state_nx = (op_q == OP_PROG) ? S_SETUP_WAIT : S_CMD_B;
            S_SETUP_WAIT: if (gap_last) state_nx = S_CMD_B;
            S_CMD_B:      state_nx = S_POLL_CMD;
            S_POLL_CMD:   state_nx = S_POLL_RD;
            S_POLL_RD:    state_nx = S_POLL_CHK;
            S_POLL_CHK: begin
                if (st_ready) begin
                    if ((op_q == OP_ERASE) || idx_last) state_nx = S_CLR_ST;
                    else                                state_nx = S_CMD_A;
                end else if (poll_last) begin
                    state_nx = S_CLR_ST;
                end else begin
                    state_nx = S_POLL_CMD;
                end
            end
            S_CLR_ST:     state_nx = S_RST_RD;
            S_RST_RD:     state_nx = S_VFY_RD;
            S_VFY_RD:     state_nx = S_VFY_CHK;
            S_VFY_CHK:    state_nx = idx_last ? S_FINISH : S_VFY_RD;
            S_FINISH:     state_nx = S_IDLE;
            default:      state_nx = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy     = (state != S_IDLE);
        done     = (state == S_FINISH);
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_wdata = 8'h00;
        fl_addr  = {bank_q, AW'(0)};
        src_addr = idx;
        unique case (state)
            S_CMD_A: begin
                fl_we = 1'b1;
                if (op_q == OP_PROG) begin
                    fl_addr  = {bank_q, idx};
                    fl_wdata = FC_PROG_ARM;
                end else begin
                    fl_wdata = FC_ERASE_ARM;
                end
            end
            S_CMD_B: begin
                fl_we = 1'b1;
                if (op_q == OP_PROG) begin
                    fl_addr  = {bank_q, idx};
                    fl_wdata = src_data;
                end else begin
                    fl_wdata = FC_ERASE_GO;
                end
            end
            S_POLL_CMD: begin
                fl_we    = 1'b1;
                fl_wdata = FC_STAT_READ;
            end
            S_POLL_RD: fl_re = 1'b1;
            S_CLR_ST: begin
                fl_we    = 1'b1;
                fl_wdata = FC_STAT_CLEAR;
            end
            S_RST_RD: begin
                fl_we    = 1'b1;
                fl_wdata = FC_ARRAY_MODE;
            end
            S_VFY_RD: begin
                fl_re   = 1'b1;
                fl_addr = {bank_q, idx};
            end
            default: ;
        endcase
    end

    // Assertions
    p_busy_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_done_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    p_erase_at_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_q == OP_ERASE) && fl_we) |-> (fl_addr[AW-1:0] == '0));

    p_gap_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= GW'(SETUP_CYC - 1));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= PW'(POLL_LIMIT - 1));

    p_timeout_wrapup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> (fl_we && (fl_wdata == FC_STAT_CLEAR)));

    p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(op_q) && $stable(bank_q)));

    p_flags_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (!timeout_flag && !vfy_fail && !dev_err && busy));

endmodule

// File: tb/flash_bank_writer_bench.sv
module flash_bank_writer_bench;

    localparam int BB = 32;
    localparam int NB = 2;
    localparam int SC = 3;
    localparam int PL = 6;
    localparam int PROG_T  = 2;
    localparam int ERASE_T = 5;
    localparam int LOGN = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       op_prog = 1'b0;
    logic [0:0] bank_sel = 1'b0;
    logic       busy, done, timeout_flag, vfy_fail, dev_err;
    logic [5:0] fl_addr;
    logic [7:0] fl_wdata;
    logic       fl_we, fl_re;
    logic [7:0] fl_rdata = 8'h00;
    logic [4:0] src_addr;
    logic [7:0] src_data = 8'h00;

    always #2 clk = ~clk;

    flash_bank_writer #(
        .BANK_BYTES(BB), .NUM_BANKS(NB), .SETUP_CYC(SC), .POLL_LIMIT(PL)
    ) u_flash_bank_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .op_prog(op_prog),
        .bank_sel(bank_sel), .busy(busy), .done(done),
        .timeout_flag(timeout_flag), .vfy_fail(vfy_fail), .dev_err(dev_err),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .src_addr(src_addr), .src_data(src_data)
    );

    // Behavioural flash device and source buffer
    logic [7:0] fmem [0:NB*BB-1];
    logic [7:0] smem [0:BB-1];
    logic [7:0] snap [0:NB*BB-1];
    int  cyc = 0;
    int  dbusy = 0;
    bit  erase_pend = 0, prog_pend = 0, stat_mode = 0;
    bit  stuck_busy = 0, err_inj = 0;
    int  stuck_addr = -1;
    int  wlog_a [0:LOGN-1];
    int  wlog_d [0:LOGN-1];
    int  wlog_c [0:LOGN-1];
    int  wn = 0;

    always @(posedge clk) begin
        bit ep;
        int a;
        cyc++;
        if (dbusy > 0) dbusy--;
        a = int'(fl_addr);
        if (fl_we) begin
            if (wn < LOGN) begin
                wlog_a[wn] = a;
                wlog_d[wn] = int'(fl_wdata);
                wlog_c[wn] = cyc;
            end
            wn++;
            if (prog_pend) begin
                fmem[a]   = fmem[a] & fl_wdata;
                prog_pend = 0;
                dbusy     = PROG_T;
                stat_mode = 1;
            end else begin
                ep = erase_pend;
                erase_pend = 0;
                case (fl_wdata)
                    8'h20: erase_pend = 1;
                    8'hD0: if (ep) begin
                        for (int k = 0; k < BB; k++) fmem[(a / BB) * BB + k] = 8'hFF;
                        dbusy     = ERASE_T;
                        stat_mode = 1;
                    end
                    8'h40: prog_pend = 1;
                    8'h70: stat_mode = 1;
                    8'hFF: stat_mode = 0;
                    default: ;
                endcase
            end
        end
        if (fl_re) begin
            if (stat_mode)
                fl_rdata <= {(dbusy == 0) && !stuck_busy, 1'b0, err_inj ? 3'b010 : 3'b000, 3'b000};
            else if (a == stuck_addr)
                fl_rdata <= fmem[a] & 8'hFE;
            else
                fl_rdata <= fmem[a];
        end
        src_data <= smem[src_addr];
    end

    int n_chk = 0, n_bad = 0;
    int flags_at_start = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int cnt_wr(input int d);
        int c = 0;
        for (int j = 0; j < wn && j < LOGN; j++) if (wlog_d[j] == d) c++;
        return c;
    endfunction

    task automatic take_snap();
        for (int i = 0; i < NB*BB; i++) snap[i] = fmem[i];
    endtask

    function automatic bit bank_same(input int bank);
        for (int i = 0; i < BB; i++) if (fmem[bank*BB+i] !== snap[bank*BB+i]) return 0;
        return 1;
    endfunction

    // Runs one operation; intrude >= 0 pulses a second start that many cycles in
    task automatic run_op(input bit prog, input int bank, input int intrude);
        int  n;
        bit  seen;
        n = 0;
        seen = 0;
        @(negedge clk);
        wn = 0;
        op_prog = prog;
        bank_sel = bank[0:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        flags_at_start = {timeout_flag, vfy_fail, dev_err};
        chk(busy == 1'b1, "R1", "busy after start", int'(busy), 1);
        while (!seen && n < 20000) begin
            if (done) begin
                seen = 1;
            end else begin
                if (!busy) chk(0, "R1", "busy dropped before done", 0, 1);
                if (n == intrude) begin
                    start = 1'b1;
                    op_prog = ~prog;
                    bank_sel = ~bank[0:0];
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                n++;
            end
        end
        start = 1'b0;
        chk(seen, "R1", "done pulse seen", int'(seen), 1);
        @(negedge clk);
        chk(!busy && !done, "R1", "idle one cycle after done", int'({busy, done}), 0);
    endtask

    task automatic check_wrapup(input int bank, input string tag);
        bit ok;
        ok = (wn >= 2) && (wlog_d[wn-2] == 8'h50) && (wlog_d[wn-1] == 8'hFF) &&
             (wlog_a[wn-2] == bank*BB) && (wlog_a[wn-1] == bank*BB);
        chk(ok, "R6", tag, (wn >= 2) ? wlog_d[wn-1] : -1, 8'hFF);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !timeout_flag && !vfy_fail && !dev_err && !fl_we && !fl_re,
            "R11", "reset state",
            int'({busy, done, timeout_flag, vfy_fail, dev_err, fl_we, fl_re}), 0);
    endtask

    task automatic t_erase(input int bank);
        bit ok;
        int base;
        base = bank * BB;
        for (int i = 0; i < BB; i++) fmem[base+i] = 8'(i ^ 8'h5A);
        take_snap();
        run_op(1'b0, bank, -1);
        chk(wlog_d[0] == 8'h20 && wlog_a[0] == base, "R2", "first erase write", wlog_d[0], 8'h20);
        chk(wlog_d[1] == 8'hD0 && wlog_a[1] == base, "R2", "erase confirm write", wlog_d[1], 8'hD0);
        ok = 1;
        for (int j = 0; j < wn; j++) if (wlog_a[j] != base) ok = 0;
        chk(ok, "R2", "all erase writes at base", int'(ok), 1);
        chk(cnt_wr(8'h70) >= 1, "R4", "status polls issued", cnt_wr(8'h70), 1);
        check_wrapup(bank, "erase wrap-up");
        ok = 1;
        for (int i = 0; i < BB; i++) if (fmem[base+i] != 8'hFF) ok = 0;
        chk(ok && !vfy_fail, "R7", "erase verify clean", int'(vfy_fail), 0);
        chk(bank_same(1 - bank), "R2", "other bank untouched", 0, 0);
        chk(!timeout_flag && !dev_err, "R5", "no timeout on erase", int'({timeout_flag, dev_err}), 0);
    endtask

    task automatic t_program(input int bank);
        bit ok;
        int base, setups;
        base = bank * BB;
        run_op(1'b1, bank, -1);
        ok = 1;
        setups = 0;
        for (int j = 0; j + 1 < wn; j++) begin
            if (wlog_d[j] == 8'h40) begin
                setups++;
                if (wlog_a[j+1] != wlog_a[j]) ok = 0;
                if (wlog_d[j+1] != int'(smem[wlog_a[j] - base])) ok = 0;
                if (wlog_c[j+1] - wlog_c[j] != SC + 1) ok = 0;
            end
        end
        chk(ok, "R3", "arm, gap and data per byte", int'(ok), 1);
        chk(setups == BB, "R3", "one arm per byte", setups, BB);
        ok = 1;
        for (int i = 0; i < BB; i++) if (fmem[base+i] != smem[i]) ok = 0;
        chk(ok && !vfy_fail, "R8", "program verify clean", int'(vfy_fail), 0);
        check_wrapup(bank, "program wrap-up");
    endtask

    task automatic t_prog_dirty();
        run_op(1'b0, 1, -1);
        fmem[BB+5] = 8'h00;
        run_op(1'b1, 1, -1);
        chk(vfy_fail == 1'b1, "R8", "unerased byte flagged", int'(vfy_fail), 1);
        chk(timeout_flag == 1'b0, "R5", "no timeout on dirty program", int'(timeout_flag), 0);
    endtask

    task automatic t_intrude();
        bit ok;
        run_op(1'b0, 0, -1);
        take_snap();
        run_op(1'b1, 0, 4);
        chk(cnt_wr(8'h20) == 0, "R10", "no erase started mid-operation", cnt_wr(8'h20), 0);
        ok = 1;
        for (int i = 0; i < BB; i++) if (fmem[i] != smem[i]) ok = 0;
        chk(ok && !vfy_fail, "R10", "running program completed", int'(vfy_fail), 0);
        chk(bank_same(1), "R10", "other bank untouched", 0, 0);
    endtask

    task automatic t_timeout();
        stuck_busy = 1;
        run_op(1'b1, 1, -1);
        stuck_busy = 0;
        chk(timeout_flag == 1'b1, "R5", "timeout raised", int'(timeout_flag), 1);
        chk(cnt_wr(8'h70) == PL, "R5", "poll count before timeout", cnt_wr(8'h70), PL);
        chk(cnt_wr(8'h40) == 1, "R5", "byte loop stopped", cnt_wr(8'h40), 1);
        check_wrapup(1, "wrap-up after timeout");
    endtask

    task automatic t_stuck_erase();
        stuck_addr = 3;
        run_op(1'b0, 0, -1);
        stuck_addr = -1;
        chk(vfy_fail == 1'b1, "R7", "stuck cell flagged after erase", int'(vfy_fail), 1);
    endtask

    task automatic t_err();
        err_inj = 1;
        run_op(1'b0, 1, -1);
        err_inj = 0;
        chk(dev_err == 1'b1, "R9", "status error bits seen", int'(dev_err), 1);
        run_op(1'b0, 1, -1);
        chk(flags_at_start == 0, "R12", "flags cleared on start", flags_at_start, 0);
        chk(dev_err == 1'b0, "R9", "clean status leaves dev_err low", int'(dev_err), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < BB; i++) smem[i] = 8'h81 + 8'(i % 15);
        for (int i = 0; i < NB*BB; i++) fmem[i] = 8'h00;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_erase(1);
        t_erase(0);
        t_program(0);
        t_prog_dirty();
        t_intrude();
        t_timeout();
        t_stuck_erase();
        t_err();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule